// File: doc/BRIEF.md
# DRAM write-command timing tracker

This block sits beside the command scheduler of one DRAM channel and answers one question on every DRAM clock: may a WRITE to a candidate rank and bank go out on this cycle? It watches every issued ACT, READ and WRITE command together with its rank and bank. It compares the clocks elapsed since those commands with four minimum-spacing limits. The limits live in a single 16-bit configuration word that the scheduler's control logic writes and reads through a plain port.

Four limits gate a WRITE:
- the spacing from an ACT to the same rank and bank;
- the spacing from the latest WRITE when that WRITE went to the same rank as the candidate;
- the spacing from the latest WRITE when that WRITE went to another rank;
- the spacing from the latest READ to any rank or bank.

The output `wr_ok` is the AND of all of them. It is combinational in the candidate inputs, so the scheduler can probe several candidates in one cycle. The block only observes. It does not block or reorder commands, and it keeps no row state.

Spacing is counted in clocks. A command issued in cycle t and a candidate presented in cycle t+k are k clocks apart. A limit L is met when k >= L.

Top module: `wr_timing_guard`

## Requirements
- R1: The configuration word is 16 bits and resets to 0000h. A write through `cfg_wr_en`/`cfg_wdata` appears on `cfg_rdata` from the next cycle, and every bit can be written and read back.
- R2: Bits [15:12] set the ACT-to-WRITE spacing. After an ACT to rank r and bank b, `wr_ok` is low for candidate (r,b) until the spacing is met. Other rank/bank pairs are not affected. The limit in force is the value held on the cycle the ACT was issued.
- R3: Bits [11:8] set the WRITE-to-WRITE spacing when the candidate rank equals the rank of the most recent WRITE.
- R4: Bits [7:4] set the WRITE-to-WRITE spacing when the candidate rank differs from the rank of the most recent WRITE. The rank of the most recent WRITE is updated by every WRITE.
- R5: Bits [3:0] set the READ-to-WRITE spacing from the most recent READ, for any candidate rank and bank.
- R6: Spacing k is the number of clocks from the issue cycle to the candidate cycle. A limit L is met when k >= L, so a limit of 0 or 1 adds no delay.
- R7: `wr_ok` is high exactly when every applicable limit is met. Out of reset, with no commands seen, `wr_ok` is high.
- R8: Command encoding on `cmd_kind`: 00 = ACT, 01 = READ, 10 = WRITE, 11 = another command. Kind 11, and any cycle with `cmd_valid` low, has no effect on the tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Value written to the configuration word |
| cfg_rdata | output | 16 | Current configuration word |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 2 | Command type (00 ACT, 01 READ, 10 WRITE, 11 other) |
| cmd_rank | input | 2 | Rank of the issued command |
| cmd_bank | input | 3 | Bank of the issued command |
| cand_rank | input | 2 | Rank of the WRITE being considered |
| cand_bank | input | 3 | Bank of the WRITE being considered |
| wr_ok | output | 1 | The candidate WRITE meets every spacing limit |

## Verification
The assertions assume that at most one command is issued per cycle. They also assume that the command and candidate fields are defined whenever they are sampled. Each limit assertion is armed only when the configuration word is not being rewritten on the command cycle, so a concurrent reprogram does not trigger a false failure.

The stimulus drives exactly one command lane with fully defined values on every cycle. It draws ranks and banks from small ranges so that same-rank and same-bank collisions are frequent. It rewrites the configuration at random points, including on command cycles, and the reference model tracks that case exactly.

// File: rtl/wrt_pkg.sv
// Package: shared types for the write-command timing tracker.
// Assumes the configuration word is exactly four 4-bit spacing fields.
package wrt_pkg;

    localparam int LIMIT_W = 4;
    localparam int CFG_W   = 4 * LIMIT_W;

    // Command code carried on cmd_kind.
    typedef enum logic [1:0] {
        KIND_ACT   = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_OTHER = 2'b11
    } cmd_kind_e;

    // Field order fixes the bit positions: act_gap is bits [15:12], rd_gap is bits [3:0].
    typedef struct packed {
        logic [LIMIT_W-1:0] act_gap;
        logic [LIMIT_W-1:0] wr_same_gap;
        logic [LIMIT_W-1:0] wr_other_gap;
        logic [LIMIT_W-1:0] rd_gap;
    } spacing_cfg_t;

    // Down-counter preload that makes a limit L satisfied exactly L clocks later.
    function automatic logic [LIMIT_W-1:0] preload(input logic [LIMIT_W-1:0] lim);
        return (lim > LIMIT_W'(1)) ? lim - LIMIT_W'(1) : '0;
    endfunction

endpackage

// File: rtl/wrt_cfg_reg.sv
// Module: holds the 16-bit spacing configuration word.
// Assumes a single writer; a write takes effect on the following cycle.
module wrt_cfg_reg
    import wrt_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [CFG_W-1:0] wdata,
    output spacing_cfg_t cfg
);

    // Purpose: load the configuration word, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg <= spacing_cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/wrt_act_tracker.sv
// Module: one down-counter per rank/bank pair for the ACT-to-WRITE spacing.
// Assumes at most one ACT per cycle; the limit is captured when the ACT issues.
module wrt_act_tracker
    import wrt_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int NUM_BANKS = 8,
    localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_fire,
    input  logic [RANK_W-1:0]  act_rank,
    input  logic [BANK_W-1:0]  act_bank,
    input  logic [LIMIT_W-1:0] act_limit,
    input  logic [RANK_W-1:0]  cand_rank,
    input  logic [BANK_W-1:0]  cand_bank,
    output logic               act_clear
);

    localparam int SLOTS = NUM_RANKS * NUM_BANKS;

    logic [LIMIT_W-1:0] remain [SLOTS];

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam int IDX = r * NUM_BANKS + b;
            logic hit;
            assign hit = act_fire && (act_rank == RANK_W'(r)) && (act_bank == BANK_W'(b));

            // Purpose: reload on an ACT to this pair, otherwise count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    remain[IDX] <= '0;
                end else if (hit) begin
                    remain[IDX] <= preload(act_limit);
                end else if (remain[IDX] != '0) begin
                    remain[IDX] <= remain[IDX] - LIMIT_W'(1);
                end
            end
        end
    end

    // Purpose: report whether the candidate pair's counter has expired.
    always_comb begin
        act_clear = 1'b1;
        for (int r = 0; r < NUM_RANKS; r++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (cand_rank == RANK_W'(r) && cand_bank == BANK_W'(b)) begin
                    act_clear = (remain[r * NUM_BANKS + b] == '0);
                end
            end
        end
    end

endmodule

// File: rtl/wrt_gap_counter.sv
// Module: saturating count of clocks since the last event.
// Assumes any limit to be compared fits in W bits; reset value means "long ago".
module wrt_gap_counter #(
    parameter int W = 4
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    output logic [W-1:0] elapsed
);

    localparam logic [W-1:0] SAT = '1;

    // Purpose: restart at one on an event, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= SAT;
        end else if (fire) begin
            elapsed <= W'(1);
        end else if (elapsed != SAT) begin
            elapsed <= elapsed + W'(1);
        end
    end

endmodule

// File: rtl/wr_timing_guard.sv
// Module: top of the write-command timing tracker for one channel.
// It combines the ACT, WRITE and READ spacing checks into wr_ok.
// Assumes one command per cycle on the cmd_* lane; wr_ok is combinational
// in cand_rank/cand_bank and refers to a WRITE issued in the current cycle.
module wr_timing_guard
    import wrt_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int NUM_BANKS = 8,
    localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [RANK_W-1:0] cmd_rank,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [RANK_W-1:0] cand_rank,
    input  logic [BANK_W-1:0] cand_bank,
    output logic              wr_ok
);

    spacing_cfg_t       cfg;
    logic               act_fire, rd_fire, wr_fire;
    logic               act_clear;
    logic [LIMIT_W-1:0] rd_elapsed, wr_elapsed;
    logic [RANK_W-1:0]  last_wr_rank;
    logic [LIMIT_W-1:0] wr_limit;

    // Purpose: decode the issued command into one strobe per tracked kind.
    always_comb begin
        act_fire = 1'b0;
        rd_fire  = 1'b0;
        wr_fire  = 1'b0;
        if (cmd_valid) begin
            case (cmd_kind_e'(cmd_kind))
                KIND_ACT:   act_fire = 1'b1;
                KIND_READ:  rd_fire  = 1'b1;
                KIND_WRITE: wr_fire  = 1'b1;
                default:    ;
            endcase
        end
    end

    wrt_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    wrt_act_tracker #(
        .NUM_RANKS (NUM_RANKS),
        .NUM_BANKS (NUM_BANKS)
    ) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_fire  (act_fire),
        .act_rank  (cmd_rank),
        .act_bank  (cmd_bank),
        .act_limit (cfg.act_gap),
        .cand_rank (cand_rank),
        .cand_bank (cand_bank),
        .act_clear (act_clear)
    );

    wrt_gap_counter #(.W(LIMIT_W)) u_rd_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (rd_fire),
        .elapsed (rd_elapsed)
    );

    wrt_gap_counter #(.W(LIMIT_W)) u_wr_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (wr_fire),
        .elapsed (wr_elapsed)
    );

    // Purpose: remember the rank of the most recent WRITE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_wr_rank <= '0;
        end else if (wr_fire) begin
            last_wr_rank <= cmd_rank;
        end
    end

    // Purpose: choose the same-rank or other-rank write spacing for the candidate.
    always_comb begin
        wr_limit = (cand_rank == last_wr_rank) ? cfg.wr_same_gap : cfg.wr_other_gap;
    end

    // Purpose: the candidate may go only when every spacing limit is met.
    always_comb begin
        wr_ok = act_clear && (wr_elapsed >= wr_limit) && (rd_elapsed >= cfg.rd_gap);
    end

    assign cfg_rdata = cfg;

endmodule

// File: rtl/wrt_guard_checker.sv
// Module: property checker for wr_timing_guard, attached with bind.
// Assumes one command per cycle with defined fields.
module wrt_guard_checker #(
    parameter int RANK_W = 2,
    parameter int BANK_W = 3
)(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [15:0]       cfg_wdata,
    input logic [15:0]       cfg_rdata,
    input logic              cmd_valid,
    input logic [1:0]        cmd_kind,
    input logic [RANK_W-1:0] cmd_rank,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [RANK_W-1:0] cand_rank,
    input logic [BANK_W-1:0] cand_bank,
    input logic              wr_ok
);

    assert_reset_clears_cfg_R1: assert property (@(posedge clk)
        !rst_n |=> cfg_rdata == 16'h0000);

    assert_cfg_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rdata == $past(cfg_wdata));

    assert_act_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'b00 && cfg_rdata[15:12] >= 4'd2)
        |=> (!wr_ok || cand_rank != $past(cmd_rank) || cand_bank != $past(cmd_bank)));

    assert_same_rank_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'b10 && !cfg_wr_en && cfg_rdata[11:8] >= 4'd2)
        |=> (!wr_ok || cand_rank != $past(cmd_rank)));

    assert_other_rank_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'b10 && !cfg_wr_en && cfg_rdata[7:4] >= 4'd2)
        |=> (!wr_ok || cand_rank == $past(cmd_rank)));

    assert_read_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'b01 && !cfg_wr_en && cfg_rdata[3:0] >= 4'd2)
        |=> !wr_ok);

endmodule

bind wr_timing_guard wrt_guard_checker #(
    .RANK_W (RANK_W),
    .BANK_W (BANK_W)
) u_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_rank  (cmd_rank),
    .cmd_bank  (cmd_bank),
    .cand_rank (cand_rank),
    .cand_bank (cand_bank),
    .wr_ok     (wr_ok)
);

// File: tb/tb_wr_timing_guard.sv
module tb_wr_timing_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic [1:0]  cmd_rank;
    logic [2:0]  cmd_bank;
    logic [1:0]  cand_rank;
    logic [2:0]  cand_bank;
    logic        wr_ok;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Reference model state
    int          cyc = 0;
    int          act_t [4][8];
    int          act_l [4][8];
    bit          act_v [4][8];
    int          wr_t, rd_t, wr_rank;
    bit          wr_v, rd_v;
    logic [15:0] m_cfg;

    wr_timing_guard dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_rank  (cmd_rank),
        .cmd_bank  (cmd_bank),
        .cand_rank (cand_rank),
        .cand_bank (cand_bank),
        .wr_ok     (wr_ok)
    );

    always #5 clk = ~clk;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not finish");
            report();
            $finish;
        end
    end

    task automatic chk(input bit cond, input string tag, input string what,
                       input int actual, input int expected);
        n_checks++;
        if (!cond) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actual, expected);
        end
    endtask

    // Expected wr_ok from the spacing rules: k clocks apart meets limit L when k >= L.
    function automatic bit exp_ok(input int cr, input int cb);
        bit ok = 1'b1;
        int lim;
        if (act_v[cr][cb] && (cyc - act_t[cr][cb]) < act_l[cr][cb]) ok = 1'b0;
        if (wr_v) begin
            lim = (cr == wr_rank) ? int'(m_cfg[11:8]) : int'(m_cfg[7:4]);
            if ((cyc - wr_t) < lim) ok = 1'b0;
        end
        if (rd_v && (cyc - rd_t) < int'(m_cfg[3:0])) ok = 1'b0;
        return ok;
    endfunction

    // Inputs are already driven; check mid-cycle, then advance the model past the edge.
    task automatic tick(input string tag);
        bit e;
        #2;
        e = exp_ok(int'(cand_rank), int'(cand_bank));
        chk(wr_ok == e, tag, "wr_ok", int'(wr_ok), int'(e));
        chk(cfg_rdata == m_cfg, "R1", "cfg_rdata", int'(cfg_rdata), int'(m_cfg));
        @(posedge clk);
        if (cmd_valid) begin
            case (cmd_kind)
                2'b00: begin
                    act_v[cmd_rank][cmd_bank] = 1'b1;
                    act_t[cmd_rank][cmd_bank] = cyc;
                    act_l[cmd_rank][cmd_bank] = int'(m_cfg[15:12]);
                end
                2'b01: begin rd_v = 1'b1; rd_t = cyc; end
                2'b10: begin wr_v = 1'b1; wr_t = cyc; wr_rank = int'(cmd_rank); end
                default: ;
            endcase
        end
        if (cfg_wr_en) m_cfg = cfg_wdata;
        cyc++;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cmd_valid = 1'b0;
    endtask

    task automatic set_cfg(input logic [15:0] v);
        cfg_wr_en = 1'b1;
        cfg_wdata = v;
        tick("R1");
    endtask

    task automatic issue(input logic [1:0] k, input int r, input int b, input string tag);
        cmd_valid = 1'b1;
        cmd_kind  = k;
        cmd_rank  = 2'(r);
        cmd_bank  = 3'(b);
        tick(tag);
    endtask

    task automatic cand(input int r, input int b);
        cand_rank = 2'(r);
        cand_bank = 3'(b);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_0042);
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wdata = '0; cmd_valid = 1'b0;
        cmd_kind = 2'b11; cmd_rank = '0; cmd_bank = '0; cand_rank = '0; cand_bank = '0;
        m_cfg = '0; wr_v = 1'b0; rd_v = 1'b0; wr_t = 0; rd_t = 0; wr_rank = 0;
        for (int r = 0; r < 4; r++)
            for (int b = 0; b < 8; b++) begin
                act_v[r][b] = 1'b0; act_t[r][b] = 0; act_l[r][b] = 0;
            end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(cfg_rdata == 16'h0000, "R1", "reset cfg_rdata", int'(cfg_rdata), 0);
        chk(wr_ok == 1'b1, "R7", "reset wr_ok", int'(wr_ok), 1);
        @(negedge clk);

        // R1: every bit writable and readable
        set_cfg(16'hA5C3);
        idle(1, "R1");
        set_cfg(16'h5A3C);
        idle(1, "R1");

        // R2: ACT spacing 5 on rank 0 bank 1, other pairs unaffected
        set_cfg(16'h5000);
        cand(0, 1);
        issue(2'b00, 0, 1, "R2");
        idle(6, "R2");
        issue(2'b00, 0, 1, "R2");
        cand(0, 2); idle(1, "R2");
        cand(1, 1); idle(1, "R2");
        cand(0, 1);
        set_cfg(16'h0000);  // R2: limit held from the ACT cycle
        idle(4, "R2");

        // R3: same-rank write spacing 4
        set_cfg(16'h0400);
        cand(1, 3);
        issue(2'b10, 1, 0, "R3");
        idle(5, "R3");
        issue(2'b10, 1, 0, "R3");
        cand(2, 3); idle(1, "R4");

        // R4: other-rank write spacing 6, rank of latest write tracked
        set_cfg(16'h0060);
        issue(2'b10, 1, 0, "R4");
        cand(2, 0); idle(7, "R4");
        set_cfg(16'h0360);
        issue(2'b10, 1, 0, "R4");
        issue(2'b10, 2, 0, "R4");
        cand(1, 0); idle(2, "R4");
        cand(2, 0); idle(4, "R3");

        // R5: read spacing 7 for any candidate
        set_cfg(16'h0007);
        issue(2'b01, 3, 5, "R5");
        cand(0, 0); idle(3, "R5");
        cand(2, 6); idle(5, "R5");

        // R6: limits of 1 and 0 add no delay
        set_cfg(16'h1111);
        cand(0, 0);
        issue(2'b00, 0, 0, "R6");
        issue(2'b01, 0, 0, "R6");
        issue(2'b10, 0, 0, "R6");
        idle(2, "R6");
        set_cfg(16'h0000);
        issue(2'b00, 0, 0, "R6");
        issue(2'b10, 1, 0, "R6");
        idle(2, "R6");

        // R8: kind 11 and cmd_valid low leave tracking untouched
        set_cfg(16'hFFFF);
        idle(16, "R8");
        cand(0, 0);
        issue(2'b11, 0, 0, "R8");
        idle(1, "R8");
        cmd_kind = 2'b00; cmd_rank = 2'd0; cmd_bank = 3'd0;
        idle(1, "R8");
        cmd_kind = 2'b10;
        idle(1, "R8");

        // R7: several limits active at once
        set_cfg(16'h3525);
        cand(0, 0);
        issue(2'b00, 0, 0, "R7");
        issue(2'b01, 2, 2, "R7");
        issue(2'b10, 1, 4, "R7");
        idle(8, "R7");

        // R7: constrained random traffic on a small rank/bank space
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 19) == 0) begin
                cfg_wr_en = 1'b1;
                cfg_wdata = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)),
                             4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
            end
            cmd_valid = ($urandom_range(0, 1) == 1);
            cmd_kind  = 2'($urandom_range(0, 3));
            cmd_rank  = 2'($urandom_range(0, 1));
            cmd_bank  = 3'($urandom_range(0, 2));
            cand_rank = 2'($urandom_range(0, 1));
            cand_bank = 3'($urandom_range(0, 2));
            tick("R7");
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule